// File: doc/BRIEF.md
# Dual-Channel Converter Write Latch

This block is the digital front end of a two-channel 12-bit converter. One 12-bit parallel bus carries the input word to both channels. Each channel has its own active-low select, and both channels share one write strobe. A channel takes the bus word when the strobe rises while that channel's select is low. When both selects are low at the rising strobe, both channels take the same word.

The strobe, the selects and the bus are all sampled on the system clock. A rising strobe is detected as high in this sample after low in the previous one. Each channel's stored code also drives a segmented switch-control word. The two top code bits are expanded into three equal-weight segment lines, each worth one quarter of full scale, in thermometer form. The ten lower bits pass straight through as binary ladder switch controls.

Top module: `dac_wr_latch`

## Requirements
- R1: While rst_n is low, and until the first write after reset, every code, segment and ladder output of both channels is zero.
- R2: On a clock edge where wr_i is sampled high and was sampled low on the previous edge, every channel whose cs_n_i bit is low stores data_i. The new code shows on code_o right after that edge.
- R3: Holding wr_i high, or holding it low, over any number of clock edges never changes a stored code, whatever data_i does.
- R4: A channel whose cs_n_i bit is high at a rising strobe keeps its code, so writes to one channel leave the other unchanged.
- R5: With both cs_n_i bits low at a rising strobe, both channels store the same data_i word.
- R6: Each channel's three segment lines form a thermometer code of code bits [11:10]. The value 0 lights none. The values 1, 2 and 3 light lines A (bit 0), then A and B (bits 1:0), then A, B and C (bits 2:0).
- R7: Each channel's ladder output equals bits [9:0] of its stored code.
- R8: The strobe history resets to "high". A strobe that is already high when reset is released causes no capture until it has gone low and risen again.
- R9: Channel n occupies code_o[12n+11:12n], seg_o[3n+2:3n] and ladder_o[10n+9:10n]. Select bit n of cs_n_i belongs to channel n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_i | input | 1 | Shared write strobe, captured on its rising transition |
| cs_n_i | input | 2 | Active-low per-channel select, bit n for channel n |
| data_i | input | 12 | Shared parallel input word |
| code_o | output | 24 | Stored codes, channel n in bits [12n+11:12n] |
| seg_o | output | 6 | Thermometer segment lines, channel n in bits [3n+2:3n] |
| ladder_o | output | 20 | Binary ladder controls, channel n in bits [10n+9:10n] |

## Verification
On every cycle, the assertions check the following:
- capture on a selected rising strobe;
- hold in all other cases;
- equality of both channels after a broadcast;
- the thermometer shape and population of the segment lines;
- the ladder pass-through.

Only the bench scenarios show three other properties. First, every select combination behaves correctly across a sweep of words that covers all four segment codes. Second, a strobe held high while data changes does nothing. Third, a strobe already high at reset release is ignored until it falls and rises again.

// File: rtl/dwl_pkg.sv
package dwl_pkg;
    localparam int DEF_NUM_CH   = 2;
    localparam int DEF_CODE_W   = 12;
    localparam int DEF_SEG_BITS = 2;

    typedef struct packed {
        logic wr;
    } strobe_state_t;
endpackage

// File: rtl/dwl_strobe_edge.sv
module dwl_strobe_edge
    import dwl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    output logic rise_o
);
    strobe_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.wr = wr_i;
        rise_o  = wr_i & ~st_q.wr;
    end

    // History resets high so a strobe held high through reset is not an edge.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q.wr <= 1'b1;
        else        st_q    <= st_d;
    end
endmodule

// File: rtl/dwl_chan_latch.sv
module dwl_chan_latch #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CODE_W-1:0] data_i,
    output logic [CODE_W-1:0] code_o
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
    } chan_state_t;

    chan_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) st_d.code = data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code_o = st_q.code;
endmodule

// File: rtl/dwl_seg_decode.sv
module dwl_seg_decode #(
    parameter int SEG_BITS = 2,
    localparam int NUM_SEG = (1 << SEG_BITS) - 1
) (
    input  logic [SEG_BITS-1:0] msb_i,
    output logic [NUM_SEG-1:0]  seg_o
);
    // Line k lights when the segment value exceeds k: fills from line 0 up.
    for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
        assign seg_o[k] = (msb_i >= SEG_BITS'(k + 1));
    end
endmodule

// File: rtl/dac_wr_latch.sv
module dac_wr_latch
    import dwl_pkg::*;
#(
    parameter int NUM_CH   = DEF_NUM_CH,
    parameter int CODE_W   = DEF_CODE_W,
    parameter int SEG_BITS = DEF_SEG_BITS,
    localparam int NUM_SEG  = (1 << SEG_BITS) - 1,
    localparam int LADDER_W = CODE_W - SEG_BITS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_i,
    input  logic [NUM_CH-1:0]            cs_n_i,
    input  logic [CODE_W-1:0]            data_i,
    output logic [NUM_CH*CODE_W-1:0]     code_o,
    output logic [NUM_CH*NUM_SEG-1:0]    seg_o,
    output logic [NUM_CH*LADDER_W-1:0]   ladder_o
);
    logic wr_rise;

    dwl_strobe_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (wr_i),
        .rise_o (wr_rise)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [CODE_W-1:0] code;

        dwl_chan_latch #(.CODE_W(CODE_W)) u_latch (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (wr_rise & ~cs_n_i[c]),
            .data_i (data_i),
            .code_o (code)
        );

        dwl_seg_decode #(.SEG_BITS(SEG_BITS)) u_seg (
            .msb_i (code[CODE_W-1 -: SEG_BITS]),
            .seg_o (seg_o[c*NUM_SEG +: NUM_SEG])
        );

        assign code_o[c*CODE_W +: CODE_W]       = code;
        assign ladder_o[c*LADDER_W +: LADDER_W] = code[LADDER_W-1:0];
    end
endmodule

// File: rtl/dwl_checker.sv
module dwl_checker #(
    parameter int NUM_CH   = 2,
    parameter int CODE_W   = 12,
    parameter int SEG_BITS = 2,
    localparam int NUM_SEG  = (1 << SEG_BITS) - 1,
    localparam int LADDER_W = CODE_W - SEG_BITS
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_i,
    input logic [NUM_CH-1:0]          cs_n_i,
    input logic [CODE_W-1:0]          data_i,
    input logic [NUM_CH*CODE_W-1:0]   code_o,
    input logic [NUM_CH*NUM_SEG-1:0]  seg_o,
    input logic [NUM_CH*LADDER_W-1:0] ladder_o
);
    logic wr_prev;
    always_ff @(posedge clk) begin
        if (!rst_n) wr_prev <= 1'b1;
        else        wr_prev <= wr_i;
    end

    logic edge_seen;
    assign edge_seen = wr_i & ~wr_prev;

    a_r1_reset_clear: assert property (@(posedge clk)
        $rose(rst_n) |-> (code_o == '0 && seg_o == '0 && ladder_o == '0));

    a_r5_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_seen && cs_n_i == '0) |=> (code_o[CODE_W-1:0] == code_o[(NUM_CH-1)*CODE_W +: CODE_W]));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_seen && !cs_n_i[c]) |=> (code_o[c*CODE_W +: CODE_W] == $past(data_i)));

        a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(edge_seen && !cs_n_i[c]) |=> $stable(code_o[c*CODE_W +: CODE_W]));

        a_r6_therm_count: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(seg_o[c*NUM_SEG +: NUM_SEG]) ==
                int'(code_o[c*CODE_W + CODE_W - 1 -: SEG_BITS]));

        a_r6_therm_shape: assert property (@(posedge clk) disable iff (!rst_n)
            ((NUM_SEG'(seg_o[c*NUM_SEG +: NUM_SEG] + 1'b1)) & seg_o[c*NUM_SEG +: NUM_SEG]) == '0);

        a_r7_ladder: assert property (@(posedge clk) disable iff (!rst_n)
            ladder_o[c*LADDER_W +: LADDER_W] == code_o[c*CODE_W +: LADDER_W]);
    end
endmodule

bind dac_wr_latch dwl_checker #(
    .NUM_CH   (NUM_CH),
    .CODE_W   (CODE_W),
    .SEG_BITS (SEG_BITS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (wr_i),
    .cs_n_i   (cs_n_i),
    .data_i   (data_i),
    .code_o   (code_o),
    .seg_o    (seg_o),
    .ladder_o (ladder_o)
);

// File: tb/dac_wr_latch_tb.sv
module dac_wr_latch_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b1;
    logic [1:0]  cs_n = 2'b11;
    logic [11:0] data = '0;
    logic [23:0] code;
    logic [5:0]  seg;
    logic [19:0] ladder;

    int n_chk = 0;
    int n_fail = 0;
    logic [11:0] exp_code [2];

    always #4 clk = ~clk;

    dac_wr_latch u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr),
        .cs_n_i   (cs_n),
        .data_i   (data),
        .code_o   (code),
        .seg_o    (seg),
        .ladder_o (ladder)
    );

    task automatic check_ch(input int ch, input string tag);
        logic [11:0] got_c;
        logic [2:0]  got_s, exp_s;
        logic [9:0]  got_l;
        int msb;
        got_c = code[ch*12 +: 12];
        got_s = seg[ch*3 +: 3];
        got_l = ladder[ch*10 +: 10];
        msb   = int'(exp_code[ch] >> 10);
        exp_s = 3'((1 << msb) - 1);
        n_chk++;
        if (got_c != exp_code[ch]) begin
            n_fail++;
            $display("FAIL %s (R9) ch%0d code got %h exp %h", tag, ch, got_c, exp_code[ch]);
        end
        n_chk++;
        if (got_s != exp_s) begin
            n_fail++;
            $display("FAIL %s R6 ch%0d seg got %b exp %b", tag, ch, got_s, exp_s);
        end
        n_chk++;
        if (got_l != exp_code[ch][9:0]) begin
            n_fail++;
            $display("FAIL %s R7 ch%0d ladder got %h exp %h", tag, ch, got_l, exp_code[ch][9:0]);
        end
    endtask

    task automatic check_all(input string tag);
        check_ch(0, tag);
        check_ch(1, tag);
    endtask

    // Strobe low for one cycle, then high at the capturing edge; sample after it.
    task automatic do_write(input logic [1:0] sel, input logic [11:0] w);
        @(negedge clk);
        wr = 1'b0;
        @(negedge clk);
        cs_n = sel;
        data = w;
        wr = 1'b1;
        if (!sel[0]) exp_code[0] = w;
        if (!sel[1]) exp_code[1] = w;
        @(negedge clk);
        cs_n = 2'b11;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        exp_code[0] = '0;
        exp_code[1] = '0;
        repeat (3) @(negedge clk);
        check_all("R1 in reset");
        // R8: strobe high across reset release, selects active, no capture
        cs_n = 2'b00;
        data = 12'hABC;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_all("R8 high strobe at release");
        check_all("R1 after release");

        // R2/R4/R5: every select combination, all four segment values
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 8; p++) begin
                logic [11:0] w;
                w = {2'(p % 4), 10'((p * 37 + s * 211 + 5) % 1024)};
                do_write(2'(s), w);
                case (s)
                    0: check_all("R5 broadcast");
                    1: check_all("R4 ch1 only");
                    2: check_all("R4 ch0 only");
                    default: check_all("R4 none selected");
                endcase
            end
        end

        // R2 distinct per-channel values
        do_write(2'b10, 12'h123);
        do_write(2'b01, 12'hFED);
        check_all("R2 distinct channels");

        // R3: strobe held high, data and selects changing
        @(negedge clk);
        wr = 1'b0;
        @(negedge clk);
        wr = 1'b1;
        cs_n = 2'b00;
        data = 12'h5A5;
        exp_code[0] = 12'h5A5;
        exp_code[1] = 12'h5A5;
        @(negedge clk);
        data = 12'h0F0;
        repeat (4) @(negedge clk);
        check_all("R3 held high");
        // R3: strobe held low
        wr = 1'b0;
        data = 12'h333;
        repeat (4) @(negedge clk);
        check_all("R3 held low");

        // R1: reset mid-run clears
        rst_n = 1'b0;
        cs_n = 2'b11;
        @(negedge clk);
        @(negedge clk);
        exp_code[0] = '0;
        exp_code[1] = '0;
        check_all("R1 reset clears");
        rst_n = 1'b1;
        do_write(2'b00, 12'hC01);
        check_all("R2 write after reset");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule